// File: doc/BRIEF.md
# Clock-Stop Status Monitor

This block sits beside a clock generator and reports, in the domain of a free-running reference clock, whether two clocks are still running. The clock generator feeds it a divide-by-two toggle of its derived output clock and a toggle of its frequency-synthesized clock. Each toggle passes through a synchronizer, and every level change seen in the reference domain counts as one sign of activity. The generator's lock indication gates both reports.

The first report, `clk_stopped`, follows the derived clock. It rises after a programmable idle time and falls again as soon as activity returns. While lock is low it is held low. The second report, `fx_stopped`, watches the synthesized clock. It latches after 100 µs without activity and stays set until reset. A third output, `rst_req`, is a one-cycle pulse on every loss of lock. It asks the surrounding logic to reset the generator.

Two state machines carry the behaviour. The stop tracker has three states. UNLOCKED moves to RUNNING when lock is high. RUNNING moves to HALTED when its idle counter expires. HALTED returns to RUNNING on activity. Any state drops to UNLOCKED when lock goes low. The synthesized-clock watcher also has three states. DISARMED moves to WATCHING when lock is high. WATCHING moves back to DISARMED when lock is lost, and to LATCHED when the 100 µs counter expires. LATCHED has no exit except reset.

Top module: `clkstop_monitor`

## Requirements
- R1: When derived-clock activity reappears while `clk_stopped` is high, the flag falls within eight reference cycles of the first new toggle level change.
- R2: `clk_stopped` is low from the first reference edge that samples `lock_in` low, and stays low for as long as `lock_in` is low. This holds even when the derived clock is idle. `lock_in` is synchronous to `clk_ref`.
- R3: With `lock_in` high, `fx_stopped` rises between FX_TIMEOUT+1 and FX_TIMEOUT+3 reference cycles after the last level change of `fxclk_tgl`. FX_TIMEOUT = REF_HZ/10000, which is 100 µs (10000 cycles at the default 100 MHz).
- R4: Once `fx_stopped` is high, it stays high until `rst` is applied. Resumed activity and loss of lock do not clear it.
- R5: With `lock_in` high, `clk_stopped` rises between STOP_CYCLES+1 and STOP_CYCLES+3 reference cycles after the last level change of `outclk_tgl`, and never earlier. The default STOP_CYCLES is 64, well above ten derived-clock periods.
- R6: `rst_req` is high for exactly one cycle: the cycle after the reference edge that first samples `lock_in` low following a sample of it high.
- R7: Each of `outclk_tgl` and `fxclk_tgl` is sampled through SYNC_STAGES flip-flops. A level change in either direction counts as activity, so a steadily toggling input keeps its flag low.
- R8: While `lock_in` is low, the synthesized-clock timer does not advance, and `fx_stopped` does not rise however long `fxclk_tgl` stays idle.
- R9: A synchronous active-high `rst` sets `clk_stopped`, `fx_stopped` and `rst_req` low at the next reference edge and restarts both timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Lock indication from the clock generator, synchronous to clk_ref |
| outclk_tgl | input | 1 | Divide-by-two toggle of the derived output clock (asynchronous) |
| fxclk_tgl | input | 1 | Divide-by-two toggle of the synthesized clock (asynchronous) |
| clk_stopped | output | 1 | Derived clock idle, gated by lock |
| fx_stopped | output | 1 | Sticky synthesized-clock-stopped flag |
| rst_req | output | 1 | One-cycle pulse on loss of lock |

## Verification
Suppose the stop tracker's state or idle counter is wrong. `clk_stopped` then moves outside the window of STOP_CYCLES+1 to STOP_CYCLES+3 cycles after the derived clock goes idle, or it fails to fall within eight cycles of activity returning. The bench brackets both edges of that window. Suppose instead the watcher leaves LATCHED, or counts while unlocked. That shows on `fx_stopped` within about a hundred cycles of the stimulus that should leave the flag unchanged. A wrong lock-edge register shows in the very next cycle as a missing, stretched or spurious `rst_req` pulse.

// File: rtl/clkstop_pkg.sv
`timescale 1ns/1ps
package clkstop_pkg;

    // Tracker for the derived output clock
    typedef enum logic [1:0] {
        STP_UNLOCKED = 2'd0,
        STP_RUNNING  = 2'd1,
        STP_HALTED   = 2'd2
    } stop_state_e;

    // Watcher for the synthesized clock
    typedef enum logic [1:0] {
        FXW_DISARMED = 2'd0,
        FXW_WATCHING = 2'd1,
        FXW_LATCHED  = 2'd2
    } fxw_state_e;

    // Reference cycles in 100 microseconds
    function automatic int unsigned cycles_per_100us(input int unsigned ref_hz);
        return ref_hz / 10_000;
    endfunction

endpackage

// File: rtl/activity_detect.sv
`timescale 1ns/1ps
// Brings an asynchronous toggle into the reference domain and pulses
// 'act' for one cycle on every level change (R7).
module activity_detect #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tgl_async,
    output logic act
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= tgl_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[STAGES-2:0], tgl_async};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[STAGES-1];
    end

    always_comb begin
        act = sync_q[STAGES-1] ^ last_q;
    end
endmodule

// File: rtl/stop_tracker.sv
`timescale 1ns/1ps
// Lock-gated idle tracker for the derived output clock (R1, R2, R5).
module stop_tracker
    import clkstop_pkg::*;
#(
    parameter int unsigned STOP_CYCLES = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic lock,
    input  logic act,
    output logic stopped
);
    localparam int unsigned CW   = $clog2(STOP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(STOP_CYCLES - 1);

    stop_state_e    st_q, st_nxt;
    logic [CW-1:0]  idle_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= STP_UNLOCKED;
        else     st_q <= st_nxt;
    end

    // Next-state logic
    always_comb begin
        st_nxt = st_q;
        if (!lock) begin
            st_nxt = STP_UNLOCKED;
        end else begin
            unique case (st_q)
                STP_UNLOCKED: st_nxt = STP_RUNNING;
                STP_RUNNING:  if (!act && idle_q == LAST) st_nxt = STP_HALTED;
                STP_HALTED:   if (act) st_nxt = STP_RUNNING;
                default:      st_nxt = STP_UNLOCKED;
            endcase
        end
    end

    // Idle counter: runs only while RUNNING, cleared by activity, saturates
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
        end else if (st_q != STP_RUNNING || act) begin
            idle_q <= '0;
        end else if (idle_q != LAST) begin
            idle_q <= idle_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        stopped = (st_q == STP_HALTED);
    end
endmodule

// File: rtl/fx_watch.sv
`timescale 1ns/1ps
// Sticky long-timeout watcher for the synthesized clock (R3, R4, R8).
module fx_watch
    import clkstop_pkg::*;
#(
    parameter int unsigned TIMEOUT = 10_000
) (
    input  logic clk,
    input  logic rst,
    input  logic lock,
    input  logic act,
    output logic latched
);
    localparam int unsigned CW   = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    fxw_state_e    st_q, st_nxt;
    logic [CW-1:0] tmr_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) st_q <= FXW_DISARMED;
        else     st_q <= st_nxt;
    end

    // Next-state logic: LATCHED has no exit but reset
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            FXW_DISARMED: if (lock) st_nxt = FXW_WATCHING;
            FXW_WATCHING: begin
                if (!lock)                         st_nxt = FXW_DISARMED;
                else if (!act && tmr_q == LAST)    st_nxt = FXW_LATCHED;
            end
            FXW_LATCHED:  st_nxt = FXW_LATCHED;
            default:      st_nxt = FXW_DISARMED;
        endcase
    end

    // Saturating timer, advancing only while watching and idle
    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q <= '0;
        end else if (st_q != FXW_WATCHING || act) begin
            tmr_q <= '0;
        end else if (tmr_q != LAST) begin
            tmr_q <= tmr_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        latched = (st_q == FXW_LATCHED);
    end
endmodule

// File: rtl/lock_loss_req.sv
`timescale 1ns/1ps
// One-cycle request on a high-to-low transition of lock (R6).
module lock_loss_req (
    input  logic clk,
    input  logic rst,
    input  logic lock,
    output logic req
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            req    <= 1'b0;
        end else begin
            lock_q <= lock;
            req    <= lock_q & ~lock;
        end
    end
endmodule

// File: rtl/clkstop_monitor.sv
`timescale 1ns/1ps
module clkstop_monitor
    import clkstop_pkg::*;
#(
    parameter int unsigned REF_HZ      = 100_000_000,
    parameter int unsigned STOP_CYCLES = 64,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic lock_in,
    input  logic outclk_tgl,
    input  logic fxclk_tgl,
    output logic clk_stopped,
    output logic fx_stopped,
    output logic rst_req
);
    localparam int unsigned FX_TIMEOUT = cycles_per_100us(REF_HZ);
    localparam int unsigned NCH        = 2;   // 0: derived, 1: synthesized

    logic [NCH-1:0] tgl_bus;
    logic [NCH-1:0] act_bus;

    always_comb begin
        tgl_bus = {fxclk_tgl, outclk_tgl};
    end

    for (genvar g = 0; g < NCH; g++) begin : g_act
        activity_detect #(.STAGES(SYNC_STAGES)) u_act (
            .clk       (clk_ref),
            .rst       (rst),
            .tgl_async (tgl_bus[g]),
            .act       (act_bus[g])
        );
    end

    stop_tracker #(.STOP_CYCLES(STOP_CYCLES)) u_stop (
        .clk     (clk_ref),
        .rst     (rst),
        .lock    (lock_in),
        .act     (act_bus[0]),
        .stopped (clk_stopped)
    );

    fx_watch #(.TIMEOUT(FX_TIMEOUT)) u_fx (
        .clk     (clk_ref),
        .rst     (rst),
        .lock    (lock_in),
        .act     (act_bus[1]),
        .latched (fx_stopped)
    );

    lock_loss_req u_req (
        .clk  (clk_ref),
        .rst  (rst),
        .lock (lock_in),
        .req  (rst_req)
    );
endmodule

// File: rtl/clkstop_monitor_chk.sv
`timescale 1ns/1ps
module clkstop_monitor_chk (
    input logic clk_ref,
    input logic rst,
    input logic lock_in,
    input logic clk_stopped,
    input logic fx_stopped,
    input logic rst_req
);
    // R2
    lock_gate_chk: assert property (@(posedge clk_ref) disable iff (rst)
        !lock_in |=> !clk_stopped);

    // R5
    stop_rise_chk: assert property (@(posedge clk_ref) disable iff (rst)
        $rose(clk_stopped) |-> $past(lock_in));

    // R3
    fx_rise_chk: assert property (@(posedge clk_ref) disable iff (rst)
        $rose(fx_stopped) |-> $past(lock_in));

    // R4
    fx_sticky_chk: assert property (@(posedge clk_ref) disable iff (rst)
        fx_stopped |=> fx_stopped);

    // R6
    req_single_chk: assert property (@(posedge clk_ref) disable iff (rst)
        rst_req |=> !rst_req);

    // R6
    req_cause_chk: assert property (@(posedge clk_ref) disable iff (rst)
        rst_req |-> !$past(lock_in));

    // R9
    reset_clear_chk: assert property (@(posedge clk_ref)
        rst |=> (!clk_stopped && !fx_stopped && !rst_req));
endmodule

bind clkstop_monitor clkstop_monitor_chk chk_i (
    .clk_ref     (clk_ref),
    .rst         (rst),
    .lock_in     (lock_in),
    .clk_stopped (clk_stopped),
    .fx_stopped  (fx_stopped),
    .rst_req     (rst_req)
);

// File: tb/clkstop_monitor_tb_top.sv
`timescale 1ns/1ps
module clkstop_monitor_tb_top;
    localparam int unsigned STOP_N = 64;
    localparam int unsigned FX_T   = 10_000;   // 100 us at 100 MHz

    logic clk_ref = 1'b0;
    logic rst = 1'b1;
    logic lock_in = 1'b0;
    logic outclk_tgl = 1'b0;
    logic fxclk_tgl = 1'b0;
    logic clk_stopped, fx_stopped, rst_req;

    logic out_run = 1'b0;
    logic fx_run  = 1'b0;
    int   out_div = 0;
    int   fx_div  = 0;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk_ref = ~clk_ref;

    clkstop_monitor #(.REF_HZ(100_000_000), .STOP_CYCLES(STOP_N), .SYNC_STAGES(2)) dut_i (
        .clk_ref(clk_ref), .rst(rst), .lock_in(lock_in),
        .outclk_tgl(outclk_tgl), .fxclk_tgl(fxclk_tgl),
        .clk_stopped(clk_stopped), .fx_stopped(fx_stopped), .rst_req(rst_req)
    );

    // Toggle generators, level change every 3 / 2 reference cycles (R7)
    always @(negedge clk_ref) begin
        if (out_run) begin
            if (out_div == 2) begin out_div <= 0; outclk_tgl <= ~outclk_tgl; end
            else out_div <= out_div + 1;
        end
        if (fx_run) begin
            if (fx_div == 1) begin fx_div <= 0; fxclk_tgl <= ~fxclk_tgl; end
            else fx_div <= fx_div + 1;
        end
    end

    typedef struct packed {
        logic        lock;
        logic        orun;
        logic        frun;
        logic [15:0] wait_n;
        logic        e_stop;
        logic        e_fx;
        logic        e_req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b1, 1'b1, 16'd20,  1'b0, 1'b0, 1'b0},  // R7 running, unlocked
        '{1'b0, 1'b0, 1'b1, 16'd200, 1'b0, 1'b0, 1'b0},  // R2 idle but unlocked
        '{1'b1, 1'b0, 1'b1, 16'd200, 1'b1, 1'b0, 1'b0},  // R5 locked and idle
        '{1'b1, 1'b1, 1'b1, 16'd20,  1'b0, 1'b0, 1'b0},  // R1 recovery
        '{1'b1, 1'b0, 1'b1, 16'd30,  1'b0, 1'b0, 1'b0},  // R5 not early
        '{1'b1, 1'b0, 1'b1, 16'd60,  1'b1, 1'b0, 1'b0},  // R5 expired
        '{1'b0, 1'b0, 1'b1, 16'd5,   1'b0, 1'b0, 1'b0},  // R2 forced low
        '{1'b1, 1'b1, 1'b1, 16'd50,  1'b0, 1'b0, 1'b0}   // R7 steady activity
    };

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic set_ctl(input logic l, input logic o, input logic f);
        @(negedge clk_ref);
        #1;
        lock_in = l; out_run = o; fx_run = f;
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic do_reset();
        @(negedge clk_ref); #1; rst = 1'b1;
        wait_neg(1);
        check("R9 clk_stopped", clk_stopped, 1'b0);
        check("R9 fx_stopped",  fx_stopped,  1'b0);
        check("R9 rst_req",     rst_req,     1'b0);
        #1; rst = 1'b0;
    endtask

    initial begin
        wait_neg(3);
        do_reset();

        // Vector table
        for (int i = 0; i < NV; i++) begin
            set_ctl(VECS[i].lock, VECS[i].orun, VECS[i].frun);
            wait_neg(int'(VECS[i].wait_n));
            check("R2/R5/R1 clk_stopped", clk_stopped, VECS[i].e_stop);
            check("R3 fx_stopped",        fx_stopped,  VECS[i].e_fx);
            check("R6 rst_req",           rst_req,     VECS[i].e_req);
        end

        // R5: window edges after the derived clock stops
        set_ctl(1'b1, 1'b1, 1'b1);
        wait_neg(20);
        set_ctl(1'b1, 1'b0, 1'b1);
        wait_neg(STOP_N);
        check("R5 not before window", clk_stopped, 1'b0);
        wait_neg(3);
        check("R5 within window", clk_stopped, 1'b1);

        // R1: recovery
        set_ctl(1'b1, 1'b1, 1'b1);
        wait_neg(8);
        check("R1 cleared on activity", clk_stopped, 1'b0);

        // R6 / R2: lock loss pulse
        set_ctl(1'b1, 1'b0, 1'b1);
        wait_neg(80);
        check("R5 stopped before lock loss", clk_stopped, 1'b1);
        set_ctl(1'b0, 1'b0, 1'b1);
        wait_neg(1);
        check("R6 pulse high", rst_req, 1'b1);
        check("R2 gated at once", clk_stopped, 1'b0);
        wait_neg(1);
        check("R6 pulse ends", rst_req, 1'b0);

        // R9: reset while the flag is high
        set_ctl(1'b1, 1'b0, 1'b1);
        wait_neg(80);
        check("R5 stopped again", clk_stopped, 1'b1);
        do_reset();

        // R3 / R4: synthesized clock timeout
        set_ctl(1'b1, 1'b1, 1'b1);
        wait_neg(20);
        set_ctl(1'b1, 1'b1, 1'b0);
        wait_neg(FX_T + 1);
        check("R3 not before 100us", fx_stopped, 1'b0);
        wait_neg(2);
        check("R3 set at 100us", fx_stopped, 1'b1);
        set_ctl(1'b1, 1'b1, 1'b1);
        wait_neg(50);
        check("R4 held after resume", fx_stopped, 1'b1);
        set_ctl(1'b0, 1'b1, 1'b1);
        wait_neg(10);
        check("R4 held after lock loss", fx_stopped, 1'b1);
        do_reset();

        // R8: no timeout while unlocked
        set_ctl(1'b0, 1'b1, 1'b0);
        wait_neg(FX_T + 20);
        check("R8 unlocked timer idle", fx_stopped, 1'b0);
        set_ctl(1'b1, 1'b1, 1'b0);
        wait_neg(FX_T / 2);
        check("R8 timer restarted at lock", fx_stopped, 1'b0);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule